// File: doc/BRIEF.md
# Complex Accumulator with Scaled Output Window

This block accumulates complex samples in two independent 20-bit lanes: a real lane fed from input port A and an imaginary lane fed from input port B. Each lane forms a new value from a fresh 16-bit operand, its own running sum, or both. A per-lane 2-bit operation code selects how they are combined. One feedback-select line and one clear line are shared by both lanes, so a new accumulation can start in the same cycle that takes in its first sample.

A 3-bit scale code chooses which 16-bit window of each 20-bit result reaches the 16-bit outputs. A single overflow flag reports two conditions: either lane's adder wrapping its 20-bit range, or either selected window losing significant upper bits. The real lane can take its operand from a copy of port A delayed by one more cycle. Output enables are modelled as registered valid flags rather than tri-state drivers.

Top module: `cplx_accum`

## Requirements
- R1: While `rst` is high, every output (`re_out`, `im_out`, `ovf`, `re_vld`, `im_vld`) reads zero from the first clock edge onward.
- R2: The A and B input registers load only on edges where `a_hold_n` or `b_hold_n` respectively is low; when it is high, the previously captured word continues to feed its lane.
- R3: All data and control inputs are captured at one rising edge, and the matching result appears on the outputs after the following edge (two edges of latency).
- R4: Operation codes (two's complement, feedback F, operand X): 2'b00 gives X, 2'b01 gives F+X, 2'b10 gives F-X, 2'b11 gives -X. The real lane uses `re_op` and the imaginary lane uses `im_op`, independently.
- R5: With `fb_sel` high, F is the lane's own 20-bit running sum; with `fb_sel` low, F is zero.
- R6: With `clr` high, F is zero for that step whatever `fb_sel` is, and the current operand is still applied.
- R7: Scale codes 0 to 4 put result bits [15+k:k] on the outputs for k equal to the code; codes 5, 6 and 7 act as code 4.
- R8: `ovf` is high when, in either lane, the result bits above the selected window are not all equal to the window's top bit.
- R9: `ovf` is high when either lane's 20-bit add or subtract overflows; the stored sum wraps modulo 2^20.
- R10: With `dly_sel` high, the real lane uses the A word captured one edge before the current one instead of the current one.
- R11: `re_vld` and `im_vld` are high one edge after `re_oe_n` and `im_oe_n` respectively are sampled low, and low one edge after they are sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Real-lane sample |
| b_in | input | 16 | Imaginary-lane sample |
| a_hold_n | input | 1 | Active-low load enable for the A register |
| b_hold_n | input | 1 | Active-low load enable for the B register |
| re_op | input | 2 | Real-lane operation code |
| im_op | input | 2 | Imaginary-lane operation code |
| clr | input | 1 | Shared clear of the feedback operand |
| fb_sel | input | 1 | Shared feedback select |
| scale | input | 3 | Output window select |
| dly_sel | input | 1 | Real lane takes the delayed A word |
| re_oe_n | input | 1 | Active-low real output enable |
| im_oe_n | input | 1 | Active-low imaginary output enable |
| re_out | output | 16 | Real-lane windowed result |
| im_out | output | 16 | Imaginary-lane windowed result |
| re_vld | output | 1 | Real output enabled |
| im_vld | output | 1 | Imaginary output enabled |
| ovf | output | 1 | Adder or window overflow in either lane |

## Verification
A vector table runs a chain of operations with each lane on a different code in the same cycle. A lane that reads the wrong control field, or an add and a subtract swapped, therefore gives a wrong running sum at once. Feedback is tried off, on, and on together with clear, which separates a zero feedback operand from a stale one. A sum just above +32767 is then viewed at scale codes 0, 1, 2 and 5, which shows window selection, the clamp of high codes and the range flag. Directed sequences hold the load enables, change the delay select between distinct A words, and accumulate up to and past the 20-bit limit, so that the flag for adder wrap is told apart from the flag for the output window.

// File: rtl/cplx_accum_pkg.sv
`timescale 1ns/1ps
package cplx_accum_pkg;
  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_NEG  = 2'b11
  } acc_op_e;

  localparam int LANES = 2;
endpackage

// File: rtl/cacc_in_stage.sv
`timescale 1ns/1ps
module cacc_in_stage
  import cplx_accum_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          a_hold_n,
  input  logic          b_hold_n,
  input  logic [1:0]    re_op,
  input  logic [1:0]    im_op,
  input  logic          clr,
  input  logic          fb_sel,
  input  logic [SW-1:0] scale,
  input  logic          dly_sel,
  output logic [DW-1:0] a_reg,
  output logic [DW-1:0] x_re,
  output logic [DW-1:0] x_im,
  output acc_op_e       op_re_q,
  output acc_op_e       op_im_q,
  output logic          clr_q,
  output logic          fb_q,
  output logic [SW-1:0] scale_q
);
  logic [DW-1:0] b_reg;
  logic [DW-1:0] a_old;
  logic          dly_q;

  // sample registers with active-low load enables
  always_ff @(posedge clk) begin
    if (rst) begin
      a_reg <= '0;
      b_reg <= '0;
      a_old <= '0;
    end else begin
      if (!a_hold_n) a_reg <= a_in;
      if (!b_hold_n) b_reg <= b_in;
      a_old <= a_reg;
    end
  end

  // control capture
  always_ff @(posedge clk) begin
    if (rst) begin
      op_re_q <= OP_PASS;
      op_im_q <= OP_PASS;
      clr_q   <= 1'b0;
      fb_q    <= 1'b0;
      scale_q <= '0;
      dly_q   <= 1'b0;
    end else begin
      op_re_q <= acc_op_e'(re_op);
      op_im_q <= acc_op_e'(im_op);
      clr_q   <= clr;
      fb_q    <= fb_sel;
      scale_q <= scale;
      dly_q   <= dly_sel;
    end
  end

  assign x_re = dly_q ? a_old : a_reg;
  assign x_im = b_reg;
endmodule

// File: rtl/cacc_lane.sv
`timescale 1ns/1ps
module cacc_lane
  import cplx_accum_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] x,
  input  acc_op_e       op,
  input  logic          fb,
  input  logic          clr,
  output logic [AW-1:0] sum,
  output logic [AW-1:0] acc_q,
  output logic          add_ovf
);
  localparam int EXT = AW + 1 - DW;

  logic [AW:0] opnd;
  logic [AW:0] fbk;
  logic [AW:0] res;

  assign opnd = {{EXT{x[DW-1]}}, x};
  assign fbk  = (fb && !clr) ? {acc_q[AW-1], acc_q} : '0;

  always_comb begin
    unique case (op)
      OP_PASS: res = opnd;
      OP_ADD:  res = fbk + opnd;
      OP_SUB:  res = fbk - opnd;
      OP_NEG:  res = '0 - opnd;
      default: res = opnd;
    endcase
  end

  assign sum     = res[AW-1:0];
  assign add_ovf = res[AW] ^ res[AW-1];

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum;
  end
endmodule

// File: rtl/cacc_window.sv
`timescale 1ns/1ps
module cacc_window #(
  parameter int AW = 20,
  parameter int OW = 16,
  parameter int SW = 3
) (
  input  logic [AW-1:0] sum,
  input  logic [SW-1:0] scale,
  output logic [OW-1:0] field,
  output logic          rng_err
);
  localparam int MAXK = AW - OW;

  logic [OW-1:0] fld [MAXK+1];
  logic [MAXK:0] err;

  for (genvar k = 0; k <= MAXK; k++) begin : g_win
    localparam int UW = AW - OW - k + 1;
    logic [UW-1:0] upper;
    assign upper  = sum[AW-1 -: UW];
    assign fld[k] = sum[OW-1+k : k];
    assign err[k] = !((&upper) || (~|upper));
  end

  always_comb begin
    field   = fld[MAXK];
    rng_err = err[MAXK];
    for (int k = 0; k < MAXK; k++) begin
      if (scale == SW'(k)) begin
        field   = fld[k];
        rng_err = err[k];
      end
    end
  end
endmodule

// File: rtl/cplx_accum.sv
`timescale 1ns/1ps
module cplx_accum
  import cplx_accum_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          a_hold_n,
  input  logic          b_hold_n,
  input  logic [1:0]    re_op,
  input  logic [1:0]    im_op,
  input  logic          clr,
  input  logic          fb_sel,
  input  logic [SW-1:0] scale,
  input  logic          dly_sel,
  input  logic          re_oe_n,
  input  logic          im_oe_n,
  output logic [DW-1:0] re_out,
  output logic [DW-1:0] im_out,
  output logic          re_vld,
  output logic          im_vld,
  output logic          ovf
);
  logic [DW-1:0] a_reg;
  logic [DW-1:0] x_re, x_im;
  acc_op_e       op_re_q, op_im_q;
  logic          clr_q, fb_q;
  logic [SW-1:0] scale_q;

  cacc_in_stage #(.DW(DW), .SW(SW)) u_in (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .a_hold_n(a_hold_n), .b_hold_n(b_hold_n),
    .re_op(re_op), .im_op(im_op), .clr(clr), .fb_sel(fb_sel),
    .scale(scale), .dly_sel(dly_sel),
    .a_reg(a_reg), .x_re(x_re), .x_im(x_im),
    .op_re_q(op_re_q), .op_im_q(op_im_q),
    .clr_q(clr_q), .fb_q(fb_q), .scale_q(scale_q)
  );

  logic [DW-1:0] x_l   [LANES];
  acc_op_e       op_l  [LANES];
  logic [AW-1:0] sum_l [LANES];
  logic [AW-1:0] acc_q [LANES];
  logic [DW-1:0] win_l [LANES];
  logic [LANES-1:0] aovf_l;
  logic [LANES-1:0] rerr_l;

  assign x_l[0]  = x_re;
  assign x_l[1]  = x_im;
  assign op_l[0] = op_re_q;
  assign op_l[1] = op_im_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cacc_lane #(.DW(DW), .AW(AW)) u_lane (
      .clk(clk), .rst(rst), .x(x_l[g]), .op(op_l[g]),
      .fb(fb_q), .clr(clr_q),
      .sum(sum_l[g]), .acc_q(acc_q[g]), .add_ovf(aovf_l[g])
    );
    cacc_window #(.AW(AW), .OW(DW), .SW(SW)) u_win (
      .sum(sum_l[g]), .scale(scale_q),
      .field(win_l[g]), .rng_err(rerr_l[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      re_out <= '0;
      im_out <= '0;
      ovf    <= 1'b0;
      re_vld <= 1'b0;
      im_vld <= 1'b0;
    end else begin
      re_out <= win_l[0];
      im_out <= win_l[1];
      ovf    <= (|aovf_l) | (|rerr_l);
      re_vld <= ~re_oe_n;
      im_vld <= ~im_oe_n;
    end
  end
endmodule

// File: rtl/cplx_accum_chk.sv
`timescale 1ns/1ps
module cplx_accum_chk
  import cplx_accum_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          a_hold_n,
  input logic          re_oe_n,
  input logic          im_oe_n,
  input logic [DW-1:0] re_out,
  input logic [DW-1:0] im_out,
  input logic          re_vld,
  input logic          im_vld,
  input logic          ovf,
  input logic [DW-1:0] a_reg,
  input logic [DW-1:0] x_re,
  input acc_op_e       op_re_q,
  input logic          clr_q,
  input logic [AW-1:0] acc_re
);
  logic [AW-1:0] x_ext;
  assign x_ext = {{(AW-DW){x_re[DW-1]}}, x_re};

  // R1
  rst_zero_chk: assert property (@(posedge clk)
    rst |=> (re_out == '0 && im_out == '0 && !ovf && !re_vld && !im_vld));

  // R11
  re_vld_on_chk: assert property (@(posedge clk) disable iff (rst)
    !re_oe_n |=> re_vld);

  // R11
  im_vld_off_chk: assert property (@(posedge clk) disable iff (rst)
    im_oe_n |=> !im_vld);

  // R2
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    a_hold_n |=> $stable(a_reg));

  // R4
  pass_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op_re_q == OP_PASS) |=> (acc_re == $past(x_ext)));

  // R6
  clr_start_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_q && op_re_q == OP_ADD) |=> (acc_re == $past(x_ext)));
endmodule

bind cplx_accum cplx_accum_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .a_hold_n(a_hold_n),
  .re_oe_n(re_oe_n), .im_oe_n(im_oe_n),
  .re_out(re_out), .im_out(im_out), .re_vld(re_vld), .im_vld(im_vld),
  .ovf(ovf), .a_reg(a_reg), .x_re(x_re), .op_re_q(op_re_q),
  .clr_q(clr_q), .acc_re(acc_q[0])
);

// File: tb/sim_cplx_accum.sv
`timescale 1ns/1ps
module sim_cplx_accum;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] a_in, b_in;
  logic        a_hold_n, b_hold_n;
  logic [1:0]  re_op, im_op;
  logic        clr, fb_sel, dly_sel;
  logic [2:0]  scale;
  logic        re_oe_n, im_oe_n;
  logic [15:0] re_out, im_out;
  logic        re_vld, im_vld, ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  cplx_accum u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .a_hold_n(a_hold_n), .b_hold_n(b_hold_n),
    .re_op(re_op), .im_op(im_op), .clr(clr), .fb_sel(fb_sel),
    .scale(scale), .dly_sel(dly_sel),
    .re_oe_n(re_oe_n), .im_oe_n(im_oe_n),
    .re_out(re_out), .im_out(im_out),
    .re_vld(re_vld), .im_vld(im_vld), .ovf(ovf)
  );

  // a, b, re_op, im_op, fb, clr, scale | exp re, exp im, exp ovf
  localparam int NV = 10;
  localparam logic [73:0] VEC [NV] = '{
    {16'h000A, 16'h0005, 2'b00, 2'b00, 1'b0, 1'b0, 3'd0, 16'h000A, 16'h0005, 1'b0},
    {16'h0003, 16'h0002, 2'b01, 2'b10, 1'b1, 1'b0, 3'd0, 16'h000D, 16'h0003, 1'b0},
    {16'h0004, 16'h0001, 2'b10, 2'b01, 1'b1, 1'b0, 3'd0, 16'h0009, 16'h0004, 1'b0},
    {16'h0007, 16'hFFFF, 2'b11, 2'b01, 1'b1, 1'b0, 3'd0, 16'hFFF9, 16'h0003, 1'b0},
    {16'h0002, 16'h0008, 2'b01, 2'b01, 1'b0, 1'b0, 3'd0, 16'h0002, 16'h0008, 1'b0},
    {16'h0064, 16'h0032, 2'b01, 2'b01, 1'b1, 1'b1, 3'd0, 16'h0064, 16'h0032, 1'b0},
    {16'h7FFF, 16'h7FFF, 2'b01, 2'b01, 1'b1, 1'b0, 3'd0, 16'h8063, 16'h8031, 1'b1},
    {16'h0000, 16'h0000, 2'b01, 2'b01, 1'b1, 1'b0, 3'd1, 16'h4031, 16'h4018, 1'b0},
    {16'h0000, 16'h0000, 2'b01, 2'b01, 1'b1, 1'b0, 3'd5, 16'h0806, 16'h0803, 1'b0},
    {16'h0000, 16'h0000, 2'b01, 2'b01, 1'b1, 1'b0, 3'd2, 16'h2018, 16'h200C, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    a_in = '0; b_in = '0; a_hold_n = 1'b0; b_hold_n = 1'b0;
    re_op = 2'b00; im_op = 2'b00; clr = 1'b0; fb_sel = 1'b0;
    scale = 3'd0; dly_sel = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    idle();
    rst = 1'b1; re_oe_n = 1'b1; im_oe_n = 1'b1;
    a_in = 16'h1234; b_in = 16'h4321; re_op = 2'b01; fb_sel = 1'b1;
    repeat (3) @(negedge clk);
    // R1 outputs held at zero under reset
    chk("R1 re_out", 32'(re_out), 32'h0);
    chk("R1 im_out", 32'(im_out), 32'h0);
    chk("R1 ovf", 32'(ovf), 32'h0);
    chk("R1 re_vld", 32'(re_vld), 32'h0);
    idle();
    rst = 1'b0;

    @(negedge clk);
    // R11 enables still high
    chk("R11 re_vld off", 32'(re_vld), 32'h0);
    re_oe_n = 1'b0;
    @(negedge clk);
    chk("R11 re_vld on", 32'(re_vld), 32'h1);
    chk("R11 im_vld off", 32'(im_vld), 32'h0);
    im_oe_n = 1'b0;
    @(negedge clk);
    chk("R11 im_vld on", 32'(im_vld), 32'h1);

    // table: vector i driven at step i, checked at step i+2 (R3 latency)
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        chk("R3/R4/R5/R6 re_out", 32'(re_out), 32'(VEC[i-2][32:17]));
        chk("R4/R5/R7 im_out", 32'(im_out), 32'(VEC[i-2][16:1]));
        chk("R8 ovf", 32'(ovf), 32'(VEC[i-2][0]));
      end
      if (i < NV) begin
        {a_in, b_in, re_op, im_op, fb_sel, clr, scale} = VEC[i][73:33];
      end else begin
        idle();
      end
      @(negedge clk);
    end

    // R2 load enables hold the captured words
    idle();
    a_in = 16'h1111; b_in = 16'h2222;
    @(negedge clk);
    a_in = 16'hAAAA; b_in = 16'hBBBB; a_hold_n = 1'b1; b_hold_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 re hold", 32'(re_out), 32'h1111);
    chk("R2 im hold", 32'(im_out), 32'h2222);
    @(negedge clk);
    chk("R2 re hold later", 32'(re_out), 32'h1111);

    // R10 delayed real operand
    idle();
    a_in = 16'h0011; b_in = 16'h0005;
    @(negedge clk);
    a_in = 16'h0022;
    @(negedge clk);
    a_in = 16'h0033; dly_sel = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 delayed re", 32'(re_out), 32'h0022);
    chk("R10 im unaffected", 32'(im_out), 32'h0005);
    dly_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 undelayed re", 32'(re_out), 32'h0033);

    // R9 accumulate 0x7FFF up to and past the 20-bit limit at scale 4
    idle();
    a_in = 16'h7FFF; re_op = 2'b01; fb_sel = 1'b1; clr = 1'b1; scale = 3'd4;
    for (int j = 1; j <= 18; j++) begin
      @(negedge clk);
      clr = 1'b0;
      if (j == 17) begin
        chk("R9 below limit re", 32'(re_out), 32'h7FFF);
        chk("R9 below limit ovf", 32'(ovf), 32'h0);
      end
      if (j == 18) begin
        chk("R9 wrapped re", 32'(re_out), 32'h87FE);
        chk("R9 adder ovf", 32'(ovf), 32'h1);
      end
    end
    idle();
    @(negedge clk);
    finish_up();
  end
endmodule